// File: doc/BRIEF.md
# Parity-Protected Word Memory with Error Injection

This block wraps a word-organized on-chip memory and keeps one parity bit for every data byte next to the data. Parity is formed when a byte is written and checked when it is read back. A read that finds a mismatch on any byte it enables returns its data unchanged. The same cycle carries a one-cycle error flag, and the word-aligned offset of the failing access is latched in a status register.

A small register port holds three registers:
- a control register with an inject enable and a status freeze;
- the captured error offset, which is read-only;
- a debug target offset.

While inject is enabled, any write that hits the target word stores inverted parity on the bytes it writes. Later reads of those bytes then fail, so software can exercise its error handling without a real fault. While the freeze bit is set, errors still raise the flag but leave the captured offset as it was.

The memory port is a simple request interface: one access per cycle, byte enables, and read data one cycle after the request. The register port has a write strobe and an address, and its read data is a combinational function of the address.

Top module: `sram_par_top`

## Requirements
- R1: After reset the control, error-offset and debug-offset registers read 0, and the read-valid and error outputs are 0.
- R2: A read request returns the stored word on `mem_rdata` with `mem_rvalid` high in the next cycle. A write updates only the bytes whose `mem_be` bit is set, where bit k covers data bits [8k+7:8k].
- R3: Reading a word whose enabled bytes were all written with inject off leaves `mem_perr` low.
- R4: While control bit 0 is 1, a write whose word-aligned offset equals the debug offset stores inverted even parity on each written byte. A later read that enables any such byte raises `mem_perr` together with `mem_rvalid`, and the data is returned as written.
- R5: While inject is on, writes to any other word store correct parity.
- R6: Register offset 0x4 bits [23:0] hold the word-aligned byte offset (low two bits zero) of the most recent read that failed parity. Each failure overwrites it, and a byte or halfword access reports the word that contains it.
- R7: While control bit 8 is 1, a failing read still raises `mem_perr` but leaves the error offset unchanged.
- R8: Parity is checked only on bytes the read enables. A read that skips the corrupted bytes of a word reports no error.
- R9: Rewriting a corrupted byte with inject off restores correct parity and clears that byte's fault.
- R10: Register offset 0x0 keeps only bits 8 and 0 and reads other bits as 0. Offset 0x8 keeps bits [23:2] and reads bits [1:0] and [31:24] as 0. Writes to offset 0x4 have no effect.
- R11: `mem_perr` is high only in a cycle where `mem_rvalid` is high, and it drops after a single failing read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_req | input | 1 | Memory access request |
| mem_we | input | 1 | 1 = write, 0 = read |
| mem_addr | input | ADDR_W | Byte address |
| mem_be | input | DATA_W/8 | Byte enables |
| mem_wdata | input | DATA_W | Write data |
| mem_rdata | output | DATA_W | Read data, valid with mem_rvalid |
| mem_rvalid | output | 1 | Read data valid, one cycle after a read request |
| mem_perr | output | 1 | Parity error on the returned read |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |

## Verification
The bench builds the block with DATA_W = 32 and DEPTH_WORDS = 16. This makes the top word, at offset 0x3C, as easy to reach as word 0, so debug-offset matching is exercised at both ends of the array. The four-lane width lets a single corrupted byte be read alongside, or around, clean neighbours within the same word. That covers enable-masked checking, halfword and byte alignment of the captured offset, and partial rewrites that repair one lane.

// File: rtl/sram_par_pkg.sv
// sram_par_pkg: shared constants and types for the parity-protected memory.
// Assumes a 32-bit register port and byte-granular parity.
package sram_par_pkg;

    localparam int FIELD_W = 24;

    localparam logic [3:0] OFS_CTRL = 4'h0;
    localparam logic [3:0] OFS_ERR  = 4'h4;
    localparam logic [3:0] OFS_DBG  = 4'h8;

    localparam int CTRL_FREEZE_BIT = 8;
    localparam int CTRL_INJECT_BIT = 0;

    typedef struct packed {
        logic status_freeze;
        logic inject_en;
    } ctrl_t;

endpackage

// File: rtl/sram_par_gen.sv
// sram_par_gen: even parity per byte lane.
// Assumes the data width is a whole number of bytes; output bit k covers byte k.
module sram_par_gen #(
    parameter int NB = 4
) (
    input  logic [NB*8-1:0] data,
    output logic [NB-1:0]   par
);

    // One XOR tree per byte lane.
    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign par[g] = ^data[g*8 +: 8];
    end

endmodule

// File: rtl/sram_par_array.sv
// sram_par_array: storage of data bytes and their parity bits.
// One write port with byte enables and one asynchronous read port.
// Contents are not reset; DEPTH must be a power of two.
module sram_par_array #(
    parameter int NB    = 4,
    parameter int DEPTH = 256,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [NB-1:0]    wr_be,
    input  logic [NB*8-1:0]  wr_data,
    input  logic [NB-1:0]    wr_par,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [NB*8-1:0]  rd_data,
    output logic [NB-1:0]    rd_par
);

    for (genvar g = 0; g < NB; g++) begin : g_lane
        logic [7:0] lane_mem [DEPTH];
        logic       lane_par [DEPTH];

        // Store the byte and its parity when this lane is enabled.
        always_ff @(posedge clk) begin
            if (wr_en && wr_be[g]) begin
                lane_mem[wr_idx] <= wr_data[g*8 +: 8];
                lane_par[wr_idx] <= wr_par[g];
            end
        end

        assign rd_data[g*8 +: 8] = lane_mem[rd_idx];
        assign rd_par[g]         = lane_par[rd_idx];
    end

endmodule

// File: rtl/sram_par_regs.sv
// sram_par_regs: control, captured error offset and debug offset registers.
// Assumes one register write per cycle and a combinational read mux.
// The error offset is captured when cap_en is high and freeze is clear.
module sram_par_regs
    import sram_par_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LSB    = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [3:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               cap_en,
    input  logic [ADDR_W-1:0]  cap_addr,
    output ctrl_t              ctrl_q,
    output logic [FIELD_W-1:0] dbg_q,
    output logic [FIELD_W-1:0] err_q
);

    logic [FIELD_W-1:0] cap_aligned;
    logic               unused_wdata;

    assign unused_wdata = ^{reg_wdata[31:FIELD_W], reg_wdata[LSB-1:0]};

    // Word-align the failing address and widen it to the field.
    always_comb begin
        cap_aligned = '0;
        cap_aligned[ADDR_W-1:LSB] = cap_addr[ADDR_W-1:LSB];
    end

    // Control register: keeps the freeze and inject bits only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (reg_we && reg_addr == OFS_CTRL) begin
            ctrl_q.status_freeze <= reg_wdata[CTRL_FREEZE_BIT];
            ctrl_q.inject_en     <= reg_wdata[CTRL_INJECT_BIT];
        end
    end

    // Debug target offset: the low bits are forced to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dbg_q <= '0;
        end else if (reg_we && reg_addr == OFS_DBG) begin
            dbg_q <= {reg_wdata[FIELD_W-1:LSB], {LSB{1'b0}}};
        end
    end

    // Captured error offset: updated by failing reads unless frozen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= '0;
        end else if (cap_en && !ctrl_q.status_freeze) begin
            err_q <= cap_aligned;
        end
    end

    // Register read mux.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CTRL: begin
                reg_rdata[CTRL_FREEZE_BIT] = ctrl_q.status_freeze;
                reg_rdata[CTRL_INJECT_BIT] = ctrl_q.inject_en;
            end
            OFS_ERR: reg_rdata[FIELD_W-1:0] = err_q;
            OFS_DBG: reg_rdata[FIELD_W-1:0] = dbg_q;
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/sram_par_top.sv
// sram_par_top: parity-protected word memory with debug error injection.
// Assumes one memory access per cycle, DATA_W a multiple of 8 with a power of
// two bytes, DEPTH_WORDS a power of two, and ADDR_W no wider than 24 bits.
// Read data, valid and error flag are registered one cycle after the request.
module sram_par_top
    import sram_par_pkg::*;
#(
    parameter  int DATA_W      = 32,
    parameter  int DEPTH_WORDS = 256,
    localparam int NB          = DATA_W / 8,
    localparam int LSB         = $clog2(NB),
    localparam int IDX_W       = $clog2(DEPTH_WORDS),
    localparam int ADDR_W      = IDX_W + LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_req,
    input  logic              mem_we,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [NB-1:0]     mem_be,
    input  logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] mem_rdata,
    output logic              mem_rvalid,
    output logic              mem_perr,
    input  logic              reg_we,
    input  logic [3:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata
);

    logic               wr_fire;
    logic               rd_fire;
    logic [IDX_W-1:0]   word_idx;
    logic [NB-1:0]      wpar_good;
    logic [NB-1:0]      wpar;
    logic [FIELD_W-1:0] wr_aligned;
    logic               inj_hit;
    logic [DATA_W-1:0]  arr_rdata;
    logic [NB-1:0]      arr_rpar;
    logic [NB-1:0]      rpar_calc;
    logic [NB-1:0]      syndrome;
    logic               perr_d;
    ctrl_t              ctrl_q;
    logic [FIELD_W-1:0] dbg_q;
    logic [FIELD_W-1:0] err_q;
    logic               rvalid_q;
    logic               perr_q;
    logic [DATA_W-1:0]  rdata_q;

    assign wr_fire  = mem_req && mem_we;
    assign rd_fire  = mem_req && !mem_we;
    assign word_idx = mem_addr[ADDR_W-1:LSB];

    // Word-aligned offset of the current access, for debug target matching.
    always_comb begin
        wr_aligned = '0;
        wr_aligned[ADDR_W-1:LSB] = word_idx;
    end

    assign inj_hit = ctrl_q.inject_en && (dbg_q == wr_aligned);
    assign wpar    = wpar_good ^ {NB{inj_hit}};

    sram_par_gen #(.NB(NB)) u_gen_wr (
        .data (mem_wdata),
        .par  (wpar_good)
    );

    sram_par_array #(.NB(NB), .DEPTH(DEPTH_WORDS)) u_array (
        .clk     (clk),
        .wr_en   (wr_fire),
        .wr_idx  (word_idx),
        .wr_be   (mem_be),
        .wr_data (mem_wdata),
        .wr_par  (wpar),
        .rd_idx  (word_idx),
        .rd_data (arr_rdata),
        .rd_par  (arr_rpar)
    );

    sram_par_gen #(.NB(NB)) u_gen_rd (
        .data (arr_rdata),
        .par  (rpar_calc)
    );

    // Mismatch is only counted on the lanes the read enables.
    assign syndrome = (rpar_calc ^ arr_rpar) & mem_be;
    assign perr_d   = |syndrome;

    sram_par_regs #(.ADDR_W(ADDR_W), .LSB(LSB)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cap_en    (rd_fire && perr_d),
        .cap_addr  (mem_addr),
        .ctrl_q    (ctrl_q),
        .dbg_q     (dbg_q),
        .err_q     (err_q)
    );

    // Read response stage: valid, error flag and data one cycle after request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q <= 1'b0;
            perr_q   <= 1'b0;
            rdata_q  <= '0;
        end else begin
            rvalid_q <= rd_fire;
            perr_q   <= rd_fire && perr_d;
            if (rd_fire) begin
                rdata_q <= arr_rdata;
            end
        end
    end

    assign mem_rvalid = rvalid_q;
    assign mem_perr   = perr_q;
    assign mem_rdata  = rdata_q;

endmodule

// File: rtl/sram_par_chk.sv
// sram_par_chk: temporal checks on the parity memory, bound into the top.
module sram_par_chk #(
    parameter int FIELD_W = 24
) (
    input logic               clk,
    input logic               rst_n,
    input logic               mem_req,
    input logic               mem_we,
    input logic               mem_rvalid,
    input logic               mem_perr,
    input logic               freeze,
    input logic [FIELD_W-1:0] err_q
);

    // R1
    reset_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!mem_rvalid && !mem_perr && err_q == '0));

    // R2
    read_gives_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> mem_rvalid);

    // R2
    no_stray_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && !mem_we) |=> !mem_rvalid);

    // R11
    perr_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_perr |-> mem_rvalid);

    // R6
    err_moves_on_perr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(err_q) |-> mem_perr);

    // R7
    frozen_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> $stable(err_q));

endmodule

bind sram_par_top sram_par_chk #(.FIELD_W(24)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_rvalid (mem_rvalid),
    .mem_perr   (mem_perr),
    .freeze     (ctrl_q.status_freeze),
    .err_q      (err_q)
);

// File: tb/test_sram_par_top.sv
module test_sram_par_top;

    localparam int DW = 32;
    localparam int DEPTH = 16;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mem_req = 1'b0;
    logic          mem_we = 1'b0;
    logic [AW-1:0] mem_addr = '0;
    logic [3:0]    mem_be = '0;
    logic [DW-1:0] mem_wdata = '0;
    logic [DW-1:0] mem_rdata;
    logic          mem_rvalid;
    logic          mem_perr;
    logic          reg_we = 1'b0;
    logic [3:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    sram_par_top #(.DATA_W(DW), .DEPTH_WORDS(DEPTH)) i_sram_par_top (
        .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid), .mem_perr(mem_perr),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    logic [31:0] m_data [int];
    logic [3:0]  m_bad  [int];
    bit          m_freeze, m_inj;
    logic [23:0] m_dbg, m_err;
    bit          exp_rvalid, exp_perr;
    logic [31:0] exp_rdata;
    int          mw;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_freeze = 0; m_inj = 0; m_dbg = '0; m_err = '0;
            exp_rvalid = 0; exp_perr = 0; exp_rdata = '0;
        end else begin
            mw = int'(mem_addr) / 4;
            exp_rvalid = 0;
            exp_perr = 0;
            if (mem_req && !mem_we) begin
                exp_rvalid = 1;
                exp_rdata = m_data.exists(mw) ? m_data[mw] : '0;
                exp_perr = m_bad.exists(mw) ? ((m_bad[mw] & mem_be) != 0) : 0;
                if (exp_perr && !m_freeze) m_err = 24'(mw * 4);
            end
            if (mem_req && mem_we) begin
                if (!m_data.exists(mw)) begin
                    m_data[mw] = '0;
                    m_bad[mw] = '0;
                end
                for (int k = 0; k < 4; k++) begin
                    if (mem_be[k]) begin
                        m_data[mw][k*8 +: 8] = mem_wdata[k*8 +: 8];
                        m_bad[mw][k] = m_inj && (m_dbg == 24'(mw * 4));
                    end
                end
            end
            if (reg_we) begin
                case (reg_addr)
                    4'h0: begin m_freeze = reg_wdata[8]; m_inj = reg_wdata[0]; end
                    4'h8: m_dbg = reg_wdata[23:0] & 24'hFFFFFC;
                    default: ;
                endcase
            end
        end
    end

    // Compare outputs with the model every cycle, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check("R2 rvalid", 32'(mem_rvalid), 32'(exp_rvalid));
            check("R4 perr", 32'(mem_perr), 32'(exp_perr));
            if (exp_rvalid) check("R2 rdata", mem_rdata, exp_rdata);
        end
    end

    task automatic mem_wr(input logic [AW-1:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        mem_req = 1; mem_we = 1; mem_addr = a; mem_be = be; mem_wdata = d;
        @(negedge clk);
        mem_req = 0; mem_we = 0;
    endtask

    task automatic mem_rd(input logic [AW-1:0] a, input logic [3:0] be,
                          input bit exp_err, input string tag);
        @(negedge clk);
        mem_req = 1; mem_we = 0; mem_addr = a; mem_be = be;
        @(negedge clk);
        mem_req = 0;
        #1;
        check(tag, 32'(mem_perr), 32'(exp_err));
    endtask

    task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic reg_chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state during and right after reset
        check("R1 rvalid", 32'(mem_rvalid), 32'h0);
        check("R1 perr", 32'(mem_perr), 32'h0);
        rst_n = 1;
        reg_chk(4'h0, 32'h0, "R1 ctrl");
        reg_chk(4'h4, 32'h0, "R1 err");
        reg_chk(4'h8, 32'h0, "R1 dbg");

        // R2 R3: fill and read back clean words
        mem_wr(6'h00, 4'hF, 32'h1111_1111);
        mem_wr(6'h04, 4'hF, 32'h2222_2222);
        mem_wr(6'h08, 4'hF, 32'hA5A5_5A5A);
        mem_wr(6'h0C, 4'hF, 32'h0F0F_F0F0);
        mem_wr(6'h10, 4'hF, 32'hDEAD_BEEF);
        mem_wr(6'h38, 4'hF, 32'h7777_0014);
        mem_wr(6'h3C, 4'hF, 32'hCAFE_0015);
        mem_rd(6'h00, 4'hF, 0, "R3 word0");
        mem_rd(6'h08, 4'hF, 0, "R3 word2");
        mem_rd(6'h3C, 4'hF, 0, "R3 word15");

        // R2: byte lane write touches only lane 2
        mem_wr(6'h06, 4'h4, 32'h0077_0000);
        mem_rd(6'h04, 4'hF, 0, "R2 byte write");
        check("R2 merged", mem_rdata, 32'h2277_2222);

        // R10: register field masking and read-only error register
        reg_wr(4'h8, 32'hFF00_000B);
        reg_chk(4'h8, 32'h0000_0008, "R10 dbg align");
        reg_wr(4'h4, 32'h0000_0123);
        reg_chk(4'h4, 32'h0, "R10 err ro");
        reg_wr(4'h0, 32'hFFFF_FFFF);
        reg_chk(4'h0, 32'h0000_0101, "R10 ctrl mask");
        reg_wr(4'h0, 32'h0);

        // R4 R5: inject into word 2, word 3 stays clean
        reg_wr(4'h0, 32'h1);
        mem_wr(6'h08, 4'hF, 32'h1234_5678);
        mem_wr(6'h0C, 4'hF, 32'h8765_4321);
        reg_wr(4'h0, 32'h0);
        mem_rd(6'h08, 4'hF, 1, "R4 injected read");
        check("R4 data kept", mem_rdata, 32'h1234_5678);
        @(negedge clk);
        check("R11 pulse drops", 32'(mem_perr), 32'h0);
        reg_chk(4'h4, 32'h0000_0008, "R6 captured");
        mem_rd(6'h0C, 4'hF, 0, "R5 other word clean");

        // R8: only lane 0 of word 4 corrupted
        reg_wr(4'h8, 32'h10);
        reg_wr(4'h0, 32'h1);
        mem_wr(6'h10, 4'h1, 32'h0000_00EE);
        reg_wr(4'h0, 32'h0);
        mem_rd(6'h11, 4'hE, 0, "R8 masked lanes");
        reg_chk(4'h4, 32'h0000_0008, "R8 err unchanged");
        mem_rd(6'h10, 4'h1, 1, "R8 bad lane");
        reg_chk(4'h4, 32'h0000_0010, "R6 overwrite");
        mem_rd(6'h0B, 4'h8, 1, "R6 byte access");
        reg_chk(4'h4, 32'h0000_0008, "R6 aligned");
        mem_rd(6'h12, 4'hC, 0, "R8 upper half clean");

        // R7: freeze keeps the offset while errors still flag
        reg_wr(4'h0, 32'h100);
        mem_rd(6'h10, 4'hF, 1, "R7 perr while frozen");
        reg_chk(4'h4, 32'h0000_0008, "R7 frozen");
        reg_wr(4'h0, 32'h0);

        // R9: clean rewrite repairs word 2
        mem_wr(6'h08, 4'hF, 32'h0BAD_F00D);
        mem_rd(6'h08, 4'hF, 0, "R9 repaired");
        check("R9 data", mem_rdata, 32'h0BAD_F00D);

        // R5 R4 R6: target the top word, its neighbour stays clean
        reg_wr(4'h8, 32'h3C);
        reg_wr(4'h0, 32'h1);
        mem_wr(6'h38, 4'hF, 32'h5555_AAAA);
        mem_wr(6'h3C, 4'h3, 32'h0000_1234);
        reg_wr(4'h0, 32'h0);
        mem_rd(6'h38, 4'hF, 0, "R5 neighbour clean");
        mem_rd(6'h3E, 4'hC, 0, "R8 top unwritten lanes");
        mem_rd(6'h3C, 4'h3, 1, "R4 top word");
        reg_chk(4'h4, 32'h0000_003C, "R6 top offset");

        repeat (2) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule